// File: doc/BRIEF.md
# Stream Cipher Session Sequencer

This block runs one complete frame session of a separate keystream core built from three majority-clocked shift registers. It drives the core through a 3-bit control word and reads back the core's single keystream bit. When a start strobe arrives while the block is idle, it latches a 64-bit session key and a 22-bit frame number. It then steps through a fixed schedule with no gaps between phases:

- a core reset,
- a forced-clock load of the key and then of the frame number,
- a run of mixing steps whose output is thrown away,
- two 114-bit keystream blocks, one for each link direction.

When both blocks are complete, a one-cycle done pulse marks them ready. They stay on the outputs until the next accepted start. A single reloadable down-counter sets the length of every phase. The whole session therefore takes a fixed number of cycles, which the surrounding logic can rely on for scheduling.

Top module: `stream_session_seq`

## Requirements
- R1: While the synchronous active-high `rst` is high at a rising edge, the block returns to idle. After that edge `busy_o`=0, `done_o`=0, `core_ctl_o`=3'b000 and both blocks are all zeros.
- R2: `start` is taken only in a cycle where `busy_o`=0. At that edge, `key_i` and `frame_i` are latched and both block outputs are cleared to zero.
- R3: For the first 4 cycles after the accepting edge, `core_ctl_o`=3'b100. The control word is laid out as follows: bit 2 is the core's synchronous reset, bit 1 forces every core register to shift, and bit 0 is the serial data bit.
- R4: For the next 64 cycles, `core_ctl_o` = {1'b0, 1'b1, key bit i}. The key bits are presented in order from bit 0 up to bit 63.
- R5: For the next 22 cycles, `core_ctl_o` = {1'b0, 1'b1, frame bit j}. The frame bits are presented in order from bit 0 up to bit 21.
- R6: For the following 100 mixing cycles and for the 228 block cycles after them, `core_ctl_o`=3'b000. Keystream produced during mixing never reaches the outputs.
- R7: Block A holds the core output observed after each of the 114 core steps that follow mixing. Each new bit is shifted in at the least significant end, so the first bit ends up in bit 113.
- R8: Block B is assembled in the same way from the 114 core steps that follow block A.
- R9: `busy_o` is high for exactly 419 cycles after the accepting edge. `done_o` is high for exactly one cycle, the 419th clock edge after the accepting edge. Both blocks keep their values after that pulse.
- R10: A `start` that arrives while `busy_o`=1 has no effect. The control schedule and both blocks are as if that `start` had not occurred, even if `key_i` and `frame_i` change at the same time.
- R11: While idle, `core_ctl_o`=3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Session start strobe |
| key_i | input | 64 | Session key |
| frame_i | input | 22 | Frame number |
| core_ctl_o | output | 3 | Control word to the core: bit 2 reset, bit 1 force-shift, bit 0 data |
| core_ks_i | input | 1 | Keystream bit from the core |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle pulse when both blocks are valid |
| blk_a_o | output | 114 | First-direction keystream block |
| blk_b_o | output | 114 | Second-direction keystream block |

## Verification
The assertions and the expected values assume two things about the core:

- it samples `core_ctl_o` on every rising edge;
- `core_ks_i` reflects its register state after that edge, with no extra latency.

The bench keeps within these assumptions by driving `core_ks_i` from a behavioural three-register core that is clocked by the same edges and fed only by `core_ctl_o`. The expected blocks come from a separate software run of the schedule, computed from the latched key and frame number. Stimulus changes only on falling edges, and stray `start` strobes are placed only inside busy windows.

// File: rtl/stream_seq_pkg.sv
package stream_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RST,
    PH_KEY,
    PH_FRAME,
    PH_MIX,
    PH_BLKA,
    PH_BLKB
  } phase_e;

  localparam int CTL_W     = 3;
  localparam int CTL_DATA  = 0;
  localparam int CTL_FORCE = 1;
  localparam int CTL_RESET = 2;

endpackage

// File: rtl/sess_phase_ctl.sv
module sess_phase_ctl
  import stream_seq_pkg::*;
#(
  parameter int RST_CYC = 4,
  parameter int KEY_W   = 64,
  parameter int FN_W    = 22,
  parameter int MIX_CYC = 100,
  parameter int BLK_W   = 114
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   go,
  output phase_e phase_o
);

  localparam int M1    = (RST_CYC > KEY_W) ? RST_CYC : KEY_W;
  localparam int M2    = (M1 > FN_W) ? M1 : FN_W;
  localparam int M3    = (M2 > MIX_CYC) ? M2 : MIX_CYC;
  localparam int MAXL  = (M3 > BLK_W) ? M3 : BLK_W;
  localparam int CNT_W = (MAXL > 2) ? $clog2(MAXL) : 1;

  phase_e           phase_q, nxt;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] reload(phase_e p);
    case (p)
      PH_RST:           return CNT_W'(RST_CYC - 1);
      PH_KEY:           return CNT_W'(KEY_W - 1);
      PH_FRAME:         return CNT_W'(FN_W - 1);
      PH_MIX:           return CNT_W'(MIX_CYC - 1);
      PH_BLKA, PH_BLKB: return CNT_W'(BLK_W - 1);
      default:          return '0;
    endcase
  endfunction

  always_comb begin
    case (phase_q)
      PH_RST:   nxt = PH_KEY;
      PH_KEY:   nxt = PH_FRAME;
      PH_FRAME: nxt = PH_MIX;
      PH_MIX:   nxt = PH_BLKA;
      PH_BLKA:  nxt = PH_BLKB;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      if (go) begin
        phase_q <= PH_RST;
        cnt_q   <= reload(PH_RST);
      end
    end else if (cnt_q == '0) begin
      phase_q <= nxt;
      cnt_q   <= reload(nxt);
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign phase_o = phase_q;

  // R3: a session always opens with the core reset phase
  a_r3_enter_via_reset: assert property (@(posedge clk) disable iff (rst)
    ($past(phase_q) == PH_IDLE && phase_q != PH_IDLE) |-> phase_q == PH_RST);

  // R9: the down-counter is parked at zero while idle
  a_r9_idle_cnt_zero: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) |-> cnt_q == '0);

endmodule

// File: rtl/sess_load_sh.sv
module sess_load_sh #(
  parameter int KEY_W = 64,
  parameter int FN_W  = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [KEY_W-1:0] key_i,
  input  logic [FN_W-1:0]  frame_i,
  output logic             bit_o
);

  localparam int SH_W = KEY_W + FN_W;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)        sh_q <= '0;
    else if (load)  sh_q <= {frame_i, key_i};
    else if (shift) sh_q <= {1'b0, sh_q[SH_W-1:1]};
  end

  assign bit_o = sh_q[0];

endmodule

// File: rtl/sess_ks_cap.sv
module sess_ks_cap #(
  parameter int BLK_W = 114
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_i,
  output logic [BLK_W-1:0] blk_o
);

  always_ff @(posedge clk) begin
    if (rst || clr) blk_o <= '0;
    else if (en)    blk_o <= {blk_o[BLK_W-2:0], bit_i};
  end

  // R7: with the lane idle the captured block does not move
  a_r7_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(blk_o));

endmodule

// File: rtl/stream_session_seq.sv
module stream_session_seq
  import stream_seq_pkg::*;
#(
  parameter int RST_CYC = 4,
  parameter int KEY_W   = 64,
  parameter int FN_W    = 22,
  parameter int MIX_CYC = 100,
  parameter int BLK_W   = 114
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [KEY_W-1:0] key_i,
  input  logic [FN_W-1:0]  frame_i,
  output logic [2:0]       core_ctl_o,
  input  logic             core_ks_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [BLK_W-1:0] blk_a_o,
  output logic [BLK_W-1:0] blk_b_o
);

  localparam int NLANE = 2;

  phase_e           phase;
  logic             accept, ld_bit, cap_vld_q, cap_sel_q, done_q;
  logic [NLANE-1:0] cap_en;
  logic [BLK_W-1:0] blk [NLANE];

  assign busy_o = (phase != PH_IDLE) || cap_vld_q;
  assign accept = start && !busy_o;

  sess_phase_ctl #(
    .RST_CYC(RST_CYC), .KEY_W(KEY_W), .FN_W(FN_W),
    .MIX_CYC(MIX_CYC), .BLK_W(BLK_W)
  ) u_phase (
    .clk(clk), .rst(rst), .go(accept), .phase_o(phase)
  );

  sess_load_sh #(.KEY_W(KEY_W), .FN_W(FN_W)) u_load (
    .clk(clk), .rst(rst), .load(accept),
    .shift(phase == PH_KEY || phase == PH_FRAME),
    .key_i(key_i), .frame_i(frame_i), .bit_o(ld_bit)
  );

  always_comb begin
    core_ctl_o = '0;
    case (phase)
      PH_RST: core_ctl_o[CTL_RESET] = 1'b1;
      PH_KEY, PH_FRAME: begin
        core_ctl_o[CTL_FORCE] = 1'b1;
        core_ctl_o[CTL_DATA]  = ld_bit;
      end
      default: ;
    endcase
  end

  // the bit a block step produces is visible one edge later
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld_q <= 1'b0;
      cap_sel_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      cap_vld_q <= (phase == PH_BLKA) || (phase == PH_BLKB);
      cap_sel_q <= (phase == PH_BLKB);
      done_q    <= cap_vld_q && cap_sel_q && (phase != PH_BLKB);
    end
  end

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign cap_en[g] = cap_vld_q && (cap_sel_q == (g != 0));
      sess_ks_cap #(.BLK_W(BLK_W)) u_cap (
        .clk(clk), .rst(rst), .clr(accept), .en(cap_en[g]),
        .bit_i(core_ks_i), .blk_o(blk[g])
      );
    end
  endgenerate

  assign blk_a_o = blk[0];
  assign blk_b_o = blk[1];
  assign done_o  = done_q;

  // R11: nothing reaches the core while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> core_ctl_o == 3'b000);

  // R3: core reset is never mixed with data or force
  a_r3_reset_alone: assert property (@(posedge clk) disable iff (rst)
    core_ctl_o[CTL_RESET] |-> (core_ctl_o[CTL_FORCE] == 1'b0 && core_ctl_o[CTL_DATA] == 1'b0));

  // R9: done lasts one cycle and only outside a session
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R2: accepting a start wipes both blocks
  a_r2_clear_on_start: assert property (@(posedge clk) disable iff (rst)
    accept |=> (blk_a_o == '0 && blk_b_o == '0));

  // R7: at most one capture lane is written per cycle
  a_r7_one_lane: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cap_en));

endmodule

// File: tb/test_stream_session_seq.sv
module test_stream_session_seq;

  localparam int  CLK_PER = 10;
  localparam int  RSTC = 4, KW = 64, FW = 22, MIXC = 100, BW = 114;
  localparam int  LAST = RSTC + KW + FW + MIXC + 2 * BW;  // last busy cycle index
  localparam int  DONE_K = LAST + 1;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [KW-1:0] key = '0;
  logic [FW-1:0] fn  = '0;
  logic [2:0]    ctl;
  logic          ks, busy, done;
  logic [BW-1:0] ba, bb;
  logic [63:0]   core_q = '0;

  int n_vec = 0, n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  stream_session_seq i_stream_session_seq (
    .clk(clk), .rst(rst), .start(start), .key_i(key), .frame_i(fn),
    .core_ctl_o(ctl), .core_ks_i(ks), .busy_o(busy), .done_o(done),
    .blk_a_o(ba), .blk_b_o(bb)
  );

  // behavioural three-register core: r1 = s[18:0], r2 = s[40:19], r3 = s[63:41]
  function automatic logic [63:0] core_step(logic [63:0] s, logic [2:0] c);
    logic [18:0] a;
    logic [21:0] b;
    logic [22:0] d;
    logic        m, fa, fb, fd;
    if (c[2]) return '0;
    a = s[18:0]; b = s[40:19]; d = s[63:41];
    m  = (a[8] & b[10]) | (a[8] & d[10]) | (b[10] & d[10]);
    fa = c[0] ^ a[13] ^ a[16] ^ a[17] ^ a[18];
    fb = c[0] ^ b[20] ^ b[21];
    fd = c[0] ^ d[7] ^ d[20] ^ d[21] ^ d[22];
    if (c[1] || a[8]  == m) a = {a[17:0], fa};
    if (c[1] || b[10] == m) b = {b[20:0], fb};
    if (c[1] || d[10] == m) d = {d[21:0], fd};
    return {d, b, a};
  endfunction

  function automatic logic core_out(logic [63:0] s);
    return s[18] ^ s[40] ^ s[63];
  endfunction

  always @(posedge clk) core_q <= core_step(core_q, ctl);
  assign ks = core_out(core_q);

  function automatic logic [2:0] exp_ctl(int k, logic [KW-1:0] kk, logic [FW-1:0] ff);
    if (k < RSTC)                 return 3'b100;
    else if (k < RSTC + KW)       return {2'b01, kk[k-RSTC]};
    else if (k < RSTC + KW + FW)  return {2'b01, ff[k-RSTC-KW]};
    else                          return 3'b000;
  endfunction

  task automatic ref_run(input logic [KW-1:0] kk, input logic [FW-1:0] ff,
                         output logic [BW-1:0] ea, output logic [BW-1:0] eb);
    logic [63:0] s;
    s = core_step(64'h1, 3'b100);
    for (int i = 0; i < KW; i++) s = core_step(s, {2'b01, kk[i]});
    for (int i = 0; i < FW; i++) s = core_step(s, {2'b01, ff[i]});
    for (int i = 0; i < MIXC; i++) s = core_step(s, 3'b000);
    ea = '0; eb = '0;
    for (int i = 0; i < BW; i++) begin s = core_step(s, 3'b000); ea = {ea[BW-2:0], core_out(s)}; end
    for (int i = 0; i < BW; i++) begin s = core_step(s, 3'b000); eb = {eb[BW-2:0], core_out(s)}; end
  endtask

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_session(input logic [KW-1:0] kk, input logic [FW-1:0] ff, input bit stray);
    logic [BW-1:0] ea, eb;
    ref_run(kk, ff, ea, eb);
    @(negedge clk);
    key = kk; fn = ff; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= DONE_K + 1; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 0) chk(ba == '0 && bb == '0, "R2 blocks cleared on start", 128'(ba ^ bb), 0);
      if (stray && k == 150) begin start = 1'b1; key = ~kk; fn = ~ff; end  // R10 stray start
      if (stray && k == 151) start = 1'b0;
      if (stray && k == 300) start = 1'b1;
      if (stray && k == 301) start = 1'b0;
      if (k <= LAST) begin
        if (k < RSTC)            chk(ctl == exp_ctl(k, kk, ff), "R3 reset phase ctl", 128'(ctl), 128'(exp_ctl(k, kk, ff)));
        else if (k < RSTC + KW)  chk(ctl == exp_ctl(k, kk, ff), "R4 key load ctl", 128'(ctl), 128'(exp_ctl(k, kk, ff)));
        else if (k < RSTC+KW+FW) chk(ctl == exp_ctl(k, kk, ff), "R5 frame load ctl", 128'(ctl), 128'(exp_ctl(k, kk, ff)));
        else if (k < LAST)       chk(ctl == 3'b000, "R6 mix/block ctl low", 128'(ctl), 0);
        chk(busy == 1'b1 && done == 1'b0, "R9 busy window", 128'({busy, done}), 128'(2'b10));
      end else if (k == DONE_K) begin
        chk(done == 1'b1 && busy == 1'b0, "R9 done pulse timing", 128'({busy, done}), 128'(2'b01));
        chk(ba == ea, "R7 block A", 128'(ba), 128'(ea));
        chk(bb == eb, "R8 block B", 128'(bb), 128'(eb));
        if (stray) chk(ba == ea && bb == eb, "R10 stray start ignored", 128'(ba), 128'(ea));
      end else begin
        chk(done == 1'b0, "R9 done one cycle", 128'(done), 0);
        chk(ba == ea && bb == eb, "R9 blocks held", 128'(bb), 128'(eb));
        chk(ctl == 3'b000, "R11 idle ctl", 128'(ctl), 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] lk;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && ctl == 0 && ba == 0 && bb == 0, "R1 reset state",
        128'({busy, done, ctl}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ctl == 3'b000 && busy == 0, "R11 idle ctl after reset", 128'(ctl), 0);

    run_session(64'hEFCDAB8967452312, 22'h000134, 1'b0);
    run_session('0, '0, 1'b0);
    run_session('1, '1, 1'b1);
    lk = 64'h0123_4567_89AB_CDEF;
    for (int i = 0; i < 4; i++) begin
      lk = lk * 64'd6364136223846793005 + 64'd1442695040888963407;
      run_session(lk, lk[63:42], (i % 2) == 1);
    end
    for (int w = 0; w < 4; w++) run_session(64'h1 << (w * 21), 22'h1 << (w * 7), 1'b0);

    // R1: reset after a finished session wipes the blocks
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(ba == 0 && bb == 0 && busy == 0 && done == 0, "R1 reset clears blocks", 128'(ba), 0);
    rst = 1'b0;

    // R1: reset in the middle of a session returns to idle
    @(negedge clk); key = 64'hA5A5_5A5A_F00F_0FF0; fn = 22'h2AAAA; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (150) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(busy == 0 && ctl == 0 && done == 0 && ba == 0, "R1 mid-session reset", 128'({busy, ctl}), 0);
    rst = 1'b0;
    run_session(64'hA5A5_5A5A_F00F_0FF0, 22'h2AAAA, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule